// File: doc/BRIEF.md
# SPI Framed Register-Access Slave

This block is an SPI slave that decodes framed transactions from a host and turns each data byte into a single access on a simple parallel memory bus. A frame opens with a 16-bit offset address and a control byte. The control byte carries a block select, a direction flag and a length mode. The data phase follows. Every data byte moves to the next offset, so one frame can stream through consecutive locations.

There are two ways to mark where a frame ends. In variable-length mode the frame runs for as long as chip-select stays low. In fixed-length mode the data phase is exactly 1, 2 or 4 bytes long. After the last byte the slave goes straight back to expecting an address, so chip-select may stay tied low and frames can follow each other with no gap. SCLK, MOSI and chip-select are synchronised into the system clock domain. The backend returns read data a fixed number of system cycles after a read strobe.

Top module: `spi_frame_slave`

## Requirements
- R1: SPI modes 0 and 3 are supported. MOSI is sampled on the rising SCLK edge and MISO changes after the falling SCLK edge. Every field is shifted most significant bit first.
- R2: A frame is made of three parts in this order: a 16-bit address, a control byte, and the data phase. In the control byte, bits [7:3] are the block select, bit 2 is the direction (1 = write, 0 = read), and bits [1:0] are the length mode.
- R3: For each complete write byte, `bus_we` pulses for exactly one cycle. During that pulse `bus_blk`, `bus_addr` and `bus_wdata` carry the frame's block, the byte's offset and the byte. `bus_we` and `bus_re` are never high in the same cycle.
- R4: In a read frame, a one-cycle `bus_re` is issued once the control byte is decoded, and again at every byte boundary that does not end a fixed-length frame. The slave captures `bus_rdata` RD_LAT clock edges after the edge at which it first samples `bus_re` high. That byte is then shifted out on MISO, most significant bit first. The first bit appears after the falling SCLK edge that closes the last control bit. This assumes that the SCLK half-period is at least RD_LAT+4 system cycles.
- R5: The offset advances by one after every data byte, in both length modes, and wraps from 0xFFFF to 0x0000.
- R6: Length mode 00 is variable length. The data phase lasts for as many bytes as the host clocks while chip-select is low.
- R7: Length modes 01, 10 and 11 give exactly 1, 2 and 4 data bytes. The bit that follows the last data bit is the address MSB of a new frame, so chip-select may stay low across frames.
- R8: Raising chip-select at any point aborts the frame. A write byte that has been only partly shifted in is never committed, and the next frame starts with its address.
- R9: While chip-select is high, no bus strobe is issued and MISO is held low.
- R10: After the synchronous reset, `bus_we`, `bus_re` and `miso` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the SCLK rate |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | SPI serial clock from the host |
| spi_cs_n | input | 1 | SPI chip-select, active low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| bus_blk | output | 5 | Block select of the current access |
| bus_addr | output | 16 | Offset of the current access |
| bus_wdata | output | 8 | Write data |
| bus_we | output | 1 | One-cycle write strobe |
| bus_re | output | 1 | One-cycle read strobe |
| bus_rdata | input | 8 | Read data, valid RD_LAT cycles after the strobe is seen |

## Verification
The bench exercises frames back to back with chip-select held low. A design that miscounted the fixed byte count would treat data as address, and every later write would land at the wrong place or vanish. A second case cuts a write off five bits into a byte. A design that kept that byte would emit an extra write that the scoreboard does not expect. The bench also runs reads in mode 3 and crosses the offset wrap at 0xFFFF. These two cases expose a MISO bit that is driven one edge late, a missing prefetch strobe, and an offset that saturates instead of wrapping. Bus strobe counts are compared per frame, so an extra or dropped prefetch on the final fixed-length byte is also caught.

// File: rtl/spi_frame_pkg.sv
package spi_frame_pkg;

  typedef enum logic {
    PH_HDR  = 1'b0,
    PH_DATA = 1'b1
  } phase_e;

  // Byte count of a fixed-length frame; zero means the frame is chip-select bounded.
  function automatic logic [2:0] fixed_len(input logic [1:0] mode);
    case (mode)
      2'b01:   fixed_len = 3'd1;
      2'b10:   fixed_len = 3'd2;
      2'b11:   fixed_len = 3'd4;
      default: fixed_len = 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk,
  input  logic cs_n,
  input  logic mosi,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_hi,
  output logic mosi_s
);

  logic [STAGES-1:0] sclk_q;
  logic [STAGES-1:0] cs_q;
  logic [STAGES-1:0] mosi_q;
  logic              sclk_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q    <= '0;
      cs_q      <= '1;
      mosi_q    <= '0;
      sclk_prev <= 1'b0;
    end else begin
      sclk_q    <= {sclk_q[STAGES-2:0], sclk};
      cs_q      <= {cs_q[STAGES-2:0], cs_n};
      mosi_q    <= {mosi_q[STAGES-2:0], mosi};
      sclk_prev <= sclk_q[STAGES-1];
    end
  end

  assign sclk_rise = sclk_q[STAGES-1] & ~sclk_prev;
  assign sclk_fall = ~sclk_q[STAGES-1] & sclk_prev;
  assign cs_hi     = cs_q[STAGES-1];
  assign mosi_s    = mosi_q[STAGES-1];

endmodule

// File: rtl/spi_rd_align.sv
module spi_rd_align #(
  parameter int RD_LAT = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_req,
  input  logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] rd_buf
);

  logic [RD_LAT-1:0] pend;

  generate
    if (RD_LAT == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) pend <= '0;
        else     pend <= rd_req;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) pend <= '0;
        else     pend <= {pend[RD_LAT-2:0], rd_req};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)                rd_buf <= '0;
    else if (pend[RD_LAT-1]) rd_buf <= rd_data;
  end

endmodule

// File: rtl/spi_frame_core.sv
module spi_frame_core
  import spi_frame_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BLK_W  = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              cs_hi,
  input  logic              mosi_s,
  input  logic [DATA_W-1:0] rd_buf,
  output logic              miso_q,
  output logic [BLK_W-1:0]  bus_blk,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_we,
  output logic              bus_re
);

  localparam int CTRL_W = BLK_W + 3;
  localparam int HDR_W  = ADDR_W + CTRL_W;
  localparam int HC_W   = $clog2(HDR_W);
  localparam int BC_W   = $clog2(DATA_W);

  phase_e             ph;
  logic [HDR_W-2:0]   hdr_sh;
  logic [HC_W-1:0]    hdr_cnt;
  logic [BC_W-1:0]    bit_cnt;
  logic [2:0]         byte_cnt;
  logic [ADDR_W-1:0]  cur_addr;
  logic [BLK_W-1:0]   cur_blk;
  logic               is_wr;
  logic [1:0]         len_mode;
  logic [DATA_W-2:0]  wsh;
  logic [DATA_W-1:0]  miso_sh;
  logic               new_byte;

  logic [HDR_W-1:0]   hdr_full;
  logic [2:0]         flen;
  logic               last_byte;

  always_comb begin
    hdr_full  = {hdr_sh, mosi_s};
    flen      = fixed_len(len_mode);
    last_byte = (flen != 3'd0) && ((byte_cnt + 3'd1) == flen);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph        <= PH_HDR;
      hdr_sh    <= '0;
      hdr_cnt   <= '0;
      bit_cnt   <= '0;
      byte_cnt  <= '0;
      cur_addr  <= '0;
      cur_blk   <= '0;
      is_wr     <= 1'b0;
      len_mode  <= 2'b00;
      wsh       <= '0;
      miso_sh   <= '0;
      new_byte  <= 1'b0;
      miso_q    <= 1'b0;
      bus_blk   <= '0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      bus_we    <= 1'b0;
      bus_re    <= 1'b0;
    end else begin
      bus_we <= 1'b0;
      bus_re <= 1'b0;
      if (cs_hi) begin
        // chip-select high: frame aborted or idle
        ph       <= PH_HDR;
        hdr_cnt  <= '0;
        bit_cnt  <= '0;
        byte_cnt <= '0;
        new_byte <= 1'b0;
        miso_q   <= 1'b0;
      end else begin
        if (sclk_rise) begin
          if (ph == PH_HDR) begin
            hdr_sh <= hdr_full[HDR_W-2:0];
            if (hdr_cnt == HC_W'(HDR_W - 1)) begin
              hdr_cnt  <= '0;
              ph       <= PH_DATA;
              cur_addr <= hdr_full[HDR_W-1 -: ADDR_W];
              cur_blk  <= hdr_full[CTRL_W-1 -: BLK_W];
              is_wr    <= hdr_full[2];
              len_mode <= hdr_full[1:0];
              bit_cnt  <= '0;
              byte_cnt <= '0;
              new_byte <= 1'b1;
              if (!hdr_full[2]) begin
                bus_re   <= 1'b1;
                bus_addr <= hdr_full[HDR_W-1 -: ADDR_W];
                bus_blk  <= hdr_full[CTRL_W-1 -: BLK_W];
              end
            end else begin
              hdr_cnt <= hdr_cnt + HC_W'(1);
            end
          end else begin
            wsh <= {wsh[DATA_W-3:0], mosi_s};
            if (bit_cnt == BC_W'(DATA_W - 1)) begin
              bit_cnt  <= '0;
              byte_cnt <= byte_cnt + 3'd1;
              cur_addr <= cur_addr + ADDR_W'(1);
              new_byte <= 1'b1;
              if (is_wr) begin
                bus_we    <= 1'b1;
                bus_addr  <= cur_addr;
                bus_blk   <= cur_blk;
                bus_wdata <= {wsh, mosi_s};
              end
              if (last_byte) begin
                ph       <= PH_HDR;
                new_byte <= 1'b0;
              end else if (!is_wr) begin
                bus_re   <= 1'b1;
                bus_addr <= cur_addr + ADDR_W'(1);
                bus_blk  <= cur_blk;
              end
            end else begin
              bit_cnt <= bit_cnt + BC_W'(1);
            end
          end
        end
        if (sclk_fall) begin
          if (ph == PH_DATA && !is_wr) begin
            if (new_byte) begin
              miso_q   <= rd_buf[DATA_W-1];
              miso_sh  <= {rd_buf[DATA_W-2:0], 1'b0};
              new_byte <= 1'b0;
            end else begin
              miso_q  <= miso_sh[DATA_W-1];
              miso_sh <= {miso_sh[DATA_W-2:0], 1'b0};
            end
          end else begin
            miso_q <= 1'b0;
          end
        end
      end
    end
  end

endmodule

// File: rtl/spi_frame_slave.sv
module spi_frame_slave #(
  parameter int ADDR_W      = 16,
  parameter int BLK_W       = 5,
  parameter int DATA_W      = 8,
  parameter int RD_LAT      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic [BLK_W-1:0]  bus_blk,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_we,
  output logic              bus_re,
  input  logic [DATA_W-1:0] bus_rdata
);

  logic              sclk_rise;
  logic              sclk_fall;
  logic              cs_hi;
  logic              mosi_s;
  logic [DATA_W-1:0] rd_buf;

  spi_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .sclk      (spi_sclk),
    .cs_n      (spi_cs_n),
    .mosi      (spi_mosi),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .cs_hi     (cs_hi),
    .mosi_s    (mosi_s)
  );

  spi_rd_align #(.RD_LAT(RD_LAT), .DATA_W(DATA_W)) u_rd (
    .clk     (clk),
    .rst     (rst),
    .rd_req  (bus_re),
    .rd_data (bus_rdata),
    .rd_buf  (rd_buf)
  );

  spi_frame_core #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .DATA_W(DATA_W)) u_core (
    .clk       (clk),
    .rst       (rst),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .cs_hi     (cs_hi),
    .mosi_s    (mosi_s),
    .rd_buf    (rd_buf),
    .miso_q    (spi_miso),
    .bus_blk   (bus_blk),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_re    (bus_re)
  );

endmodule

// File: rtl/spi_frame_slave_chk.sv
module spi_frame_slave_chk (
  input logic clk,
  input logic rst,
  input logic spi_cs_n,
  input logic spi_miso,
  input logic bus_we,
  input logic bus_re
);

  // R3: strobes never overlap
  p_strobe_excl_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({bus_we, bus_re}));

  // R3: a write strobe lasts one cycle
  p_we_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    bus_we |=> !bus_we);

  // R4: a read strobe lasts one cycle
  p_re_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    bus_re |=> !bus_re);

  // R9: no strobes once chip-select has been high long enough to pass the synchroniser
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    ($past(spi_cs_n, 1) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3) && $past(spi_cs_n, 4))
      |-> (!bus_we && !bus_re));

  // R9: MISO low while deselected
  p_miso_idle_r9: assert property (@(posedge clk) disable iff (rst)
    ($past(spi_cs_n, 1) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3) && $past(spi_cs_n, 4))
      |-> !spi_miso);

endmodule

bind spi_frame_slave spi_frame_slave_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .spi_cs_n (spi_cs_n),
  .spi_miso (spi_miso),
  .bus_we   (bus_we),
  .bus_re   (bus_re)
);

// File: tb/spi_frame_slave_bench.sv
module spi_frame_slave_bench;

  localparam int H = 8;   // SCLK half-period in system cycles

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sclk = 1'b0;
  logic        cs_n = 1'b1;
  logic        mosi = 1'b0;
  logic        miso;
  logic [4:0]  bus_blk;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata;
  logic        bus_we;
  logic        bus_re;
  logic [7:0]  bus_rdata = 8'h00;

  int tests = 0;
  int fails = 0;
  int we_cnt = 0;
  int re_cnt = 0;
  logic [28:0] exp_q[$];

  always #2 clk = ~clk;

  spi_frame_slave u_spi_frame_slave (
    .clk       (clk),
    .rst       (rst),
    .spi_sclk  (sclk),
    .spi_cs_n  (cs_n),
    .spi_mosi  (mosi),
    .spi_miso  (miso),
    .bus_blk   (bus_blk),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_rdata (bus_rdata)
  );

  function automatic logic [7:0] mem_val(input logic [4:0] b, input logic [15:0] a);
    mem_val = a[7:0] ^ a[15:8] ^ {b, 3'b101};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // backend model: data appears after the strobe and stays until the next one
  always @(posedge clk) if (bus_re) bus_rdata <= mem_val(bus_blk, bus_addr);

  // scoreboard monitor for writes and strobe counting
  always @(negedge clk) begin
    if (!rst && bus_re) re_cnt++;
    if (!rst && bus_we) begin
      we_cnt++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R3/R8 unexpected write", {bus_blk, bus_addr, bus_wdata}, 0);
      end else begin
        logic [28:0] e;
        e = exp_q.pop_front();
        check({bus_blk, bus_addr, bus_wdata} == e, "R3/R5 write", {bus_blk, bus_addr, bus_wdata}, e);
      end
    end
  end

  task automatic wait_h();
    repeat (H) @(negedge clk);
  endtask

  task automatic xfer_bit(input bit m3, input logic b, output logic r);
    if (m3) begin
      sclk = 1'b0; mosi = b; wait_h(); r = miso; sclk = 1'b1; wait_h();
    end else begin
      mosi = b; wait_h(); r = miso; sclk = 1'b1; wait_h(); sclk = 1'b0;
    end
  endtask

  task automatic xfer_byte(input bit m3, input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      logic r;
      xfer_bit(m3, tx[i], r);
      rx[i] = r;
    end
  endtask

  task automatic run_frame(input bit m3, input bit use_cs, input logic [4:0] blk,
                           input logic [15:0] addr, input bit wr, input logic [1:0] om,
                           input int n, input logic [7:0] seed);
    logic [7:0] rx;
    logic [15:0] a;
    if (use_cs) begin
      sclk = m3; wait_h(); cs_n = 1'b0; wait_h();
    end
    xfer_byte(m3, addr[15:8], rx);
    xfer_byte(m3, addr[7:0], rx);
    xfer_byte(m3, {blk, wr, om}, rx);
    for (int i = 0; i < n; i++) begin
      a = addr + 16'(i);
      if (wr) exp_q.push_back({blk, a, seed + 8'(i)});
      xfer_byte(m3, seed + 8'(i), rx);
      if (!wr) check(rx == mem_val(blk, a), "R4/R5 read byte", rx, mem_val(blk, a));
    end
    if (use_cs) begin
      wait_h(); cs_n = 1'b1; repeat (4 * H) @(negedge clk);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int w0, r0;
    logic r;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    check(!bus_we && !bus_re && !miso, "R10 reset outputs", {bus_we, bus_re, miso}, 0);

    // R1 R2 R3 R5 R6: mode 0 variable-length write, three bytes
    run_frame(1'b0, 1'b1, 5'h05, 16'h1234, 1'b1, 2'b00, 3, 8'hC3);
    check(exp_q.size() == 0, "R6 all variable writes seen", exp_q.size(), 0);

    // R1 R4: mode 3 variable-length read, four bytes, five strobes incl. prefetch
    r0 = re_cnt;
    run_frame(1'b1, 1'b1, 5'h1A, 16'h00F0, 1'b0, 2'b00, 4, 8'h00);
    check(re_cnt - r0 == 5, "R4 read strobe count", re_cnt - r0, 5);

    // R7: fixed-length frames back to back, chip-select held low
    sclk = 1'b0; wait_h(); cs_n = 1'b0; wait_h();
    run_frame(1'b0, 1'b0, 5'h02, 16'h4000, 1'b1, 2'b10, 2, 8'h10);
    r0 = re_cnt;
    run_frame(1'b0, 1'b0, 5'h03, 16'h5006, 1'b0, 2'b11, 4, 8'h00);
    check(re_cnt - r0 == 4, "R7 fixed read strobe count", re_cnt - r0, 4);
    run_frame(1'b0, 1'b0, 5'h1F, 16'h6001, 1'b1, 2'b01, 1, 8'h7E);
    wait_h(); cs_n = 1'b1; repeat (4 * H) @(negedge clk);
    check(exp_q.size() == 0, "R7 fixed writes all seen", exp_q.size(), 0);

    // R8: abort five bits into the second write byte
    w0 = we_cnt;
    sclk = 1'b0; wait_h(); cs_n = 1'b0; wait_h();
    begin
      logic [7:0] rx;
      xfer_byte(1'b0, 8'h02, rx);
      xfer_byte(1'b0, 8'h00, rx);
      xfer_byte(1'b0, {5'h03, 1'b1, 2'b00}, rx);
      exp_q.push_back({5'h03, 16'h0200, 8'hA5});
      xfer_byte(1'b0, 8'hA5, rx);
      for (int i = 0; i < 5; i++) xfer_bit(1'b0, 1'b1, r);
    end
    wait_h(); cs_n = 1'b1; repeat (4 * H) @(negedge clk);
    check(we_cnt - w0 == 1, "R8 partial byte dropped", we_cnt - w0, 1);
    run_frame(1'b0, 1'b1, 5'h04, 16'h0300, 1'b1, 2'b00, 1, 8'h5A);
    check(we_cnt - w0 == 2, "R8 next frame after abort", we_cnt - w0, 2);

    // R9: clocking with chip-select high does nothing
    w0 = we_cnt; r0 = re_cnt;
    for (int i = 0; i < 40; i++) begin
      xfer_bit(1'b0, i[0], r);
      check(r == 1'b0, "R9 miso idle", r, 0);
    end
    check(we_cnt == w0 && re_cnt == r0, "R9 no strobes while deselected", we_cnt - w0 + re_cnt - r0, 0);

    // R5: offset wrap in write and read
    run_frame(1'b0, 1'b1, 5'h06, 16'hFFFF, 1'b1, 2'b00, 2, 8'h90);
    run_frame(1'b1, 1'b1, 5'h07, 16'hFFFE, 1'b0, 2'b00, 3, 8'h00);
    check(exp_q.size() == 0, "R5 wrap writes all seen", exp_q.size(), 0);

    summary();
  end

endmodule